// File: doc/BRIEF.md
# Chainable Gated PWM Timer

This block is a bank of identical up-counting PWM timers that share one clock. Each stage counts from zero up to its reload value, wraps back to zero, and emits a one-cycle update pulse on the wrap. A PWM output is active while the count is below the stage's compare value. Each stage can run freely, or it can run in gated mode. In gated mode the counter moves only in cycles where a chosen trigger line is high. Each trigger line carries the update pulse of one stage.

A master stage runs free. A slave stage is gated by the master's update pulse, so it advances once per master period. That slave can in turn gate a further stage, and the frequency is divided at each step of the chain. With the default of three stages, stage 0 can run free, stage 1 can be gated by stage 0, and stage 2 can be gated by stage 1.

Software-side programming arrives on a single-cycle write port. The port selects a stage and a field. Reload and compare writes go to preload registers. Those values reach the working registers at the next wrap, so a running PWM period is never cut short. While a stage is disabled, its preload values are copied every cycle.

Top module: `cascade_pwm_timer`

## Requirements
- R1: After a synchronous active-high reset, every counter is zero, every stage is disabled, and all PWM and trigger outputs are low.
- R2: An enabled stage with reload value A wraps every A+1 advances. Its trigger output is high for exactly the one cycle that follows each wrap. With A=0 the trigger stays high while the stage runs.
- R3: The PWM output of an enabled stage is high while its count is below the compare value C. This gives C high cycles out of every A+1.
- R4: A compare value of zero keeps the PWM output low. A compare value greater than the reload value keeps it high for the whole period.
- R5: A stage whose enable bit is clear holds its count, raises no trigger and drives its PWM output low, even if its gate line is pulsing.
- R6: In gated mode an enabled stage advances only in cycles where its selected trigger line is high. Otherwise it holds its count, so its period is the gate source's period times A+1.
- R7: The trigger select field S gates a stage with the update pulse of stage S. Any stage may be chosen, and a value with no matching stage never opens the gate.
- R8: A running stage applies reload and compare writes at its next wrap. It finishes the current period with the old values. A disabled stage takes them within one cycle.
- R9: Three stages chained master to slave to slave divide the update rate by the product of their periods (A0+1)(A1+1)(A2+1).
- R10: The write port is decoded by the field code on `wr_addr`: 0 is control, 1 is reload, 2 is compare, and 3 is ignored. The control word on `wr_data` is bit 0 enable, bit 1 gated mode, and bits 3:2 trigger select. A write lands at the clock edge where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of all stages |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_stage | input | 2 | Index of the stage being written |
| wr_addr | input | 2 | Field code: 0 control, 1 reload, 2 compare |
| wr_data | input | 16 | Write data (control word uses bits 3:0) |
| pwm_o | output | 3 | PWM output of each stage |
| trig_o | output | 3 | One-cycle update pulse of each stage |

## Verification
Period and duty are measured on a table of reload and compare pairs. The table includes reload zero, compare zero, compare equal to reload plus one, and compare well above reload. A design that compared with the wrong inequality would be off by one cycle in duty. A design that wrapped late would be off by one cycle in period.

In the cascade, the bench measures each slave's period as the product of the stage periods. A gate that was level-sensitive for longer than one cycle would make a slave run too fast. The bench also re-points a slave's trigger select and checks the new product.

A reload written mid-period must leave the current period untouched and change only the next one. A design without the preload stage would shorten the running period. Finally, a disabled slave and a slave whose master is stopped are both watched for any trigger or PWM activity.

// File: rtl/cascade_tmr_pkg.sv
package cascade_tmr_pkg;

    // Width of the trigger select field of the control word.
    localparam int SEL_W  = 2;
    localparam int CTRL_W = SEL_W + 2;

    typedef enum logic [1:0] {
        FLD_CTRL    = 2'd0,
        FLD_RELOAD  = 2'd1,
        FLD_COMPARE = 2'd2,
        FLD_NONE    = 2'd3
    } field_e;

    // Packed so that bit 0 is enable, bit 1 gated, bits 3:2 select.
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             gated;
        logic             en;
    } ctrl_t;

    typedef struct packed {
        logic hit_ctrl;
        logic hit_reload;
        logic hit_compare;
    } wr_hit_t;

    function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] bits);
        ctrl_t c;
        c.en    = bits[0];
        c.gated = bits[1];
        c.sel   = bits[2 +: SEL_W];
        return c;
    endfunction

    function automatic wr_hit_t decode_field(input logic stage_hit,
                                             input logic [1:0] addr);
        wr_hit_t h;
        h = '0;
        if (stage_hit) begin
            case (field_e'(addr))
                FLD_CTRL:    h.hit_ctrl    = 1'b1;
                FLD_RELOAD:  h.hit_reload  = 1'b1;
                FLD_COMPARE: h.hit_compare = 1'b1;
                default:     h = '0;
            endcase
        end
        return h;
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import cascade_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_hit_t          hit,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load_evt,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload_act,
    output logic [CNT_W-1:0] compare_act
);

    logic [CNT_W-1:0] reload_pre;
    logic [CNT_W-1:0] compare_pre;

    // Control applies at once; reload and compare go through a preload
    // stage that is copied on a wrap, or every cycle while disabled.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl        <= '0;
            reload_pre  <= '0;
            compare_pre <= '0;
            reload_act  <= '0;
            compare_act <= '0;
        end else begin
            if (hit.hit_ctrl)    ctrl        <= ctrl_unpack(wr_data[CTRL_W-1:0]);
            if (hit.hit_reload)  reload_pre  <= wr_data;
            if (hit.hit_compare) compare_pre <= wr_data;
            if (load_evt || !ctrl.en) begin
                reload_act  <= reload_pre;
                compare_act <= compare_pre;
            end
        end
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic [CNT_W-1:0] reload_act,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             upd_pulse
);

    // Wrap on >= so a reload lowered below the count still recovers.
    assign wrap = advance && (cnt >= reload_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            upd_pulse <= 1'b0;
        end else begin
            upd_pulse <= wrap;
            if (advance) begin
                cnt <= wrap ? '0 : cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/tmr_stage.sv
module tmr_stage
    import cascade_tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int N_LINES = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_hit_t            hit,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [N_LINES-1:0] trig_lines,
    output logic               pwm,
    output logic               trig_out,
    output ctrl_t              ctrl,
    output logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   reload_act,
    output logic [CNT_W-1:0]   compare_act
);

    logic gate_line;
    logic advance;
    logic wrap;

    // Select one internal trigger line; an unmatched code keeps the gate shut.
    always_comb begin
        gate_line = 1'b0;
        for (int k = 0; k < N_LINES; k++) begin
            if (ctrl.sel == SEL_W'(k)) gate_line = trig_lines[k];
        end
    end

    assign advance = ctrl.en && (!ctrl.gated || gate_line);

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit),
        .wr_data     (wr_data),
        .load_evt    (wrap),
        .ctrl        (ctrl),
        .reload_act  (reload_act),
        .compare_act (compare_act)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .advance    (advance),
        .reload_act (reload_act),
        .cnt        (cnt),
        .wrap       (wrap),
        .upd_pulse  (trig_out)
    );

    assign pwm = ctrl.en && (cnt < compare_act);

endmodule

// File: rtl/cascade_pwm_timer.sv
module cascade_pwm_timer
    import cascade_tmr_pkg::*;
#(
    parameter int N_STAGES = 3,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_stage,
    input  logic [1:0]          wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output logic [N_STAGES-1:0] pwm_o,
    output logic [N_STAGES-1:0] trig_o
);

    logic [N_STAGES-1:0]                 trig_w;
    logic [N_STAGES-1:0]                 en_w;
    logic [N_STAGES-1:0]                 gated_w;
    logic [N_STAGES-1:0][SEL_W-1:0]      sel_w;
    logic [N_STAGES-1:0][CNT_W-1:0]      cnt_w;
    logic [N_STAGES-1:0][CNT_W-1:0]      reload_w;
    logic [N_STAGES-1:0][CNT_W-1:0]      compare_w;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        wr_hit_t hit;
        ctrl_t   ctrl;

        assign hit = decode_field(wr_en && (wr_stage == IDX_W'(i)), wr_addr);

        tmr_stage #(.CNT_W(CNT_W), .N_LINES(N_STAGES)) u_stage (
            .clk         (clk),
            .rst         (rst),
            .hit         (hit),
            .wr_data     (wr_data),
            .trig_lines  (trig_w),
            .pwm         (pwm_o[i]),
            .trig_out    (trig_w[i]),
            .ctrl        (ctrl),
            .cnt         (cnt_w[i]),
            .reload_act  (reload_w[i]),
            .compare_act (compare_w[i])
        );

        assign en_w[i]    = ctrl.en;
        assign gated_w[i] = ctrl.gated;
        assign sel_w[i]   = ctrl.sel;
    end

    assign trig_o = trig_w;

endmodule

// File: rtl/cascade_pwm_timer_chk.sv
module cascade_pwm_timer_chk #(
    parameter int N_STAGES = 3,
    parameter int CNT_W    = 16
) (
    input logic                                         clk,
    input logic                                         rst,
    input logic [N_STAGES-1:0]                          pwm_o,
    input logic [N_STAGES-1:0]                          trig_o,
    input logic [N_STAGES-1:0]                          en_w,
    input logic [N_STAGES-1:0]                          gated_w,
    input logic [N_STAGES-1:0][cascade_tmr_pkg::SEL_W-1:0] sel_w,
    input logic [N_STAGES-1:0][CNT_W-1:0]               cnt_w,
    input logic [N_STAGES-1:0][CNT_W-1:0]               reload_w,
    input logic [N_STAGES-1:0][CNT_W-1:0]               compare_w
);

    for (genvar i = 0; i < N_STAGES; i++) begin : g_chk
        logic gate_open;
        always_comb begin
            gate_open = 1'b0;
            for (int k = 0; k < N_STAGES; k++) begin
                if (int'(sel_w[i]) == k) gate_open = trig_o[k];
            end
        end

        assert_trig_after_wrap_R2: assert property (@(posedge clk) disable iff (rst)
            trig_o[i] |-> cnt_w[i] == '0)
            else $error("trigger without wrap on stage %0d", i);

        assert_off_holds_count_R5: assert property (@(posedge clk) disable iff (rst)
            !en_w[i] |=> $stable(cnt_w[i]))
            else $error("disabled stage %0d moved", i);

        assert_off_pwm_low_R5: assert property (@(posedge clk) disable iff (rst)
            !en_w[i] |-> !pwm_o[i])
            else $error("disabled stage %0d drives pwm", i);

        assert_gate_closed_holds_R6: assert property (@(posedge clk) disable iff (rst)
            (en_w[i] && gated_w[i] && !gate_open) |=> $stable(cnt_w[i]))
            else $error("gated stage %0d moved without trigger", i);

        assert_cmp_over_reload_high_R4: assert property (@(posedge clk) disable iff (rst)
            (en_w[i] && compare_w[i] > reload_w[i] && cnt_w[i] <= reload_w[i]) |-> pwm_o[i])
            else $error("stage %0d pwm not constant high", i);

        assert_cmp_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
            (compare_w[i] == '0) |-> !pwm_o[i])
            else $error("stage %0d pwm high with zero compare", i);

        assert_reload_swap_at_wrap_R8: assert property (@(posedge clk) disable iff (rst)
            (en_w[i] && $past(en_w[i]) && !$stable(reload_w[i])) |-> cnt_w[i] == '0)
            else $error("stage %0d reload changed mid-period", i);
    end

endmodule

bind cascade_pwm_timer cascade_pwm_timer_chk #(
    .N_STAGES (N_STAGES),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwm_o     (pwm_o),
    .trig_o    (trig_o),
    .en_w      (en_w),
    .gated_w   (gated_w),
    .sel_w     (sel_w),
    .cnt_w     (cnt_w),
    .reload_w  (reload_w),
    .compare_w (compare_w)
);

// File: tb/cascade_pwm_timer_tb.sv
`timescale 1ns/1ps
module cascade_pwm_timer_tb;

    localparam int N  = 3;
    localparam int W  = 16;
    localparam int LIMIT = 3000;

    // Field codes and control word layout (R10).
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_RELOAD = 2'd1;
    localparam logic [1:0] A_COMPARE = 2'd2;

    // Stage 0 period/duty table: {reload, compare} (R2, R3, R4).
    localparam int TBL_N = 6;
    localparam int TBL [TBL_N][2] = '{
        '{7, 2}, '{9, 0}, '{4, 9}, '{5, 6}, '{0, 1}, '{15, 15}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_stage = '0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [N-1:0] pwm_o;
    logic [N-1:0] trig_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cascade_pwm_timer #(.N_STAGES(N), .CNT_W(W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_stage (wr_stage),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pwm_o    (pwm_o),
        .trig_o   (trig_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ctrl_word(input int en, input int gated, input int sel);
        return W'(en & 1) | (W'(gated & 1) << 1) | (W'(sel & 3) << 2);
    endfunction

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic wr(input int stage, input logic [1:0] addr, input logic [W-1:0] data);
        wr_en    = 1'b1;
        wr_stage = 2'(stage);
        wr_addr  = addr;
        wr_data  = data;
        @(posedge clk);
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Sync to a trigger, then count cycles and PWM-high cycles to the next one.
    task automatic measure(input int s, output int period, output int high);
        int guard = 0;
        while (!trig_o[s] && guard < LIMIT) begin
            guard++;
            @(negedge clk);
        end
        period = 0;
        high   = 0;
        do begin
            high += int'(pwm_o[s]);
            period++;
            @(negedge clk);
        end while (!trig_o[s] && period < LIMIT);
    endtask

    task automatic program_stage(input int s, input int rl, input int cp,
                                 input int gated, input int sel);
        wr(s, A_CTRL, ctrl_word(0, gated, sel));
        wr(s, A_RELOAD, W'(rl));
        wr(s, A_COMPARE, W'(cp));
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int per;
        int hi;
        int cnt_c;
        int t_cnt;
        int p_cnt;
        logic prev;

        // R1: reset state
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 pwm in reset", int'(pwm_o), 0);
        check("R1 trig in reset", int'(trig_o), 0);
        rst = 1'b0;
        idle(3);
        check("R1 pwm after reset", int'(pwm_o), 0);
        check("R1 trig after reset", int'(trig_o), 0);

        // R2 R3 R4 R10: table walk on free-running stage 0
        for (int t = 0; t < TBL_N; t++) begin
            int rl = TBL[t][0];
            int cp = TBL[t][1];
            program_stage(0, rl, cp, 0, 0);
            wr(0, A_CTRL, ctrl_word(1, 0, 0));
            measure(0, per, hi);
            check($sformatf("R2 period reload=%0d", rl), per, rl + 1);
            check($sformatf("R3/R4 high reload=%0d compare=%0d", rl, cp), hi,
                  (cp > rl) ? rl + 1 : cp);
        end

        // R9 R6: three-stage cascade 0 -> 1 -> 2
        program_stage(0, 3, 1, 0, 0);
        program_stage(1, 3, 1, 1, 0);
        program_stage(2, 1, 1, 1, 1);
        wr(2, A_CTRL, ctrl_word(1, 1, 1));
        wr(1, A_CTRL, ctrl_word(1, 1, 0));
        wr(0, A_CTRL, ctrl_word(1, 0, 0));
        measure(0, per, hi);
        check("R9 stage0 period", per, 4);
        check("R9 stage0 high", hi, 1);
        measure(1, per, hi);
        check("R6 stage1 period", per, 16);
        check("R6 stage1 high", hi, 4);
        measure(2, per, hi);
        check("R9 stage2 period", per, 32);
        check("R9 stage2 high", hi, 16);

        // R7: re-point stage 2 at stage 0
        wr(2, A_CTRL, ctrl_word(1, 1, 0));
        measure(2, per, hi);
        measure(2, per, hi);
        check("R7 stage2 on line0 period", per, 8);
        check("R7 stage2 on line0 high", hi, 4);

        // R8: reload written just after a wrap applies one period later
        t_cnt = 0;
        while (!trig_o[0] && t_cnt < LIMIT) begin
            t_cnt++;
            @(negedge clk);
        end
        cnt_c = 1;
        wr(0, A_RELOAD, W'(5));
        hi = int'(pwm_o[0]);
        while (!trig_o[0] && cnt_c < LIMIT) begin
            cnt_c++;
            @(negedge clk);
        end
        check("R8 current period keeps old reload", cnt_c, 4);
        measure(0, per, hi);
        check("R8 next period uses new reload", per, 6);
        check("R8 next period high", hi, 1);

        // R5: disabled stage ignores its pulsing gate
        wr(2, A_CTRL, ctrl_word(0, 1, 0));
        wr(2, A_COMPARE, W'(2));
        t_cnt = 0;
        p_cnt = 0;
        for (int k = 0; k < 100; k++) begin
            t_cnt += int'(trig_o[2]);
            p_cnt += int'(pwm_o[2]);
            @(negedge clk);
        end
        check("R5 disabled stage triggers", t_cnt, 0);
        check("R5 disabled stage pwm", p_cnt, 0);

        // R6: gated stage holds while its master is stopped
        wr(0, A_CTRL, ctrl_word(0, 0, 0));
        idle(2);
        t_cnt = 0;
        p_cnt = 0;
        prev  = pwm_o[1];
        for (int k = 0; k < 100; k++) begin
            t_cnt += int'(trig_o[1]);
            if (pwm_o[1] != prev) p_cnt++;
            prev = pwm_o[1];
            @(negedge clk);
        end
        check("R6 held slave triggers", t_cnt, 0);
        check("R6 held slave pwm edges", p_cnt, 0);

        // R10: field code 3 changes nothing; stage 0 stays stopped
        wr(0, 2'd3, ctrl_word(1, 0, 0));
        t_cnt = 0;
        for (int k = 0; k < 20; k++) begin
            t_cnt += int'(trig_o[0]);
            @(negedge clk);
        end
        check("R10 unused field code ignored", t_cnt, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule